// File: doc/BRIEF.md
# Motor Speed Detector for a Frequency-Locked Loop

This block is the digital half of a motor speed regulation loop. It runs on a reference oscillator clock. It derives a once-per-revolution tachometer signal, either by dividing the commutation-event toggle stream or by passing through an external sector/index input. Each rising edge of that tachometer starts a reference pulse whose length, in oscillator cycles, comes from a 14-bit active-low speed word.

The block then compares the falling edges of the tachometer and the reference. When the tachometer falls first, the motor is too fast, and an overspeed pulse is driven for the gap between the two edges. When the reference falls first, the motor is too slow, and an underspeed pulse is driven for the gap. These pulses steer an external charge pump.

A startup flag stays high from reset until the first overspeed pulse, so the analog side can drive the motor at full current while it accelerates. A busy indication tells the controller when it is safe to change the tachometer source.

Top module: `fll_speed_detector`

## Requirements
- R1: In divider mode (`sector_mode` = 0), `tach` toggles once for every 3 × P toggles of `fcom`, where P is selected by `pole_sel`: 2'b00 gives P = 8, 2'b01 gives P = 4, 2'b10 gives P = 16 and 2'b11 gives P = 12.
- R2: In sector mode (`sector_mode` = 1), `tach` follows `sector_in` and changes on the third rising clock edge after the input changes.
- R3: `ref_pulse` rises in the same cycle as `tach` rises. It stays high for N cycles, where N is the bitwise inverse of `speed_word_n` read as an unsigned binary number, so bit i carries weight 2^i when it is driven low.
- R4: `err_fast` is high in exactly the cycles where `ref_pulse` is still high after `tach` has fallen.
- R5: `err_slow` is high in exactly the cycles where `tach` is still high after `ref_pulse` has ended.
- R6: When both falling edges occur in the same cycle, neither error output is asserted.
- R7: `yank` is 1 after reset. It goes to 0 on the clock edge after the first cycle with `err_fast` high, and it stays 0 until the next reset.
- R8: `sync` is high whenever `tach` or `ref_pulse` is high, and low otherwise.
- R9: While `rst_n` is low, `tach`, `ref_pulse`, `err_fast`, `err_slow` and `sync` are 0 and `yank` is 1.
- R10: If the speed word is all ones (N = 0), no reference pulse is produced, and `err_slow` is high for the whole time `tach` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference oscillator clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fcom | input | 1 | Commutation event signal; toggles at each back-EMF zero crossing (asynchronous) |
| sector_in | input | 1 | External sector/index tachometer (asynchronous) |
| sector_mode | input | 1 | 1 selects `sector_in` as the tachometer source |
| pole_sel | input | 2 | Motor pole count code |
| speed_word_n | input | 14 | Active-low reference length |
| tach | output | 1 | Once-per-revolution tachometer |
| ref_pulse | output | 1 | Reference pulse |
| err_fast | output | 1 | Overspeed pulse to the charge pump |
| err_slow | output | 1 | Underspeed pulse to the charge pump |
| yank | output | 1 | Startup flag |
| sync | output | 1 | Measurement in progress |

## Verification
The assertions check on every cycle the relations that do not depend on a scenario:
- a reference pulse only starts together with a tachometer rise;
- the divider count stays in range;
- the startup flag never comes back once it has cleared, and it always clears after an overspeed pulse.

The bench scenarios are needed for the rest:
- the exact number of `fcom` toggles behind each pole code;
- the sector input latency;
- the length of the reference pulse for given speed words;
- the width of each error pulse for a tachometer that is too short, too long, or set against a zero-length reference.

// File: rtl/fll_speed_detector.sv
module fll_speed_detector #(
  parameter int SPEED_W = 14,
  parameter int DIV_W   = 6
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               fcom,
  input  logic               sector_in,
  input  logic               sector_mode,
  input  logic [1:0]         pole_sel,
  input  logic [SPEED_W-1:0] speed_word_n,
  output logic               tach,
  output logic               ref_pulse,
  output logic               err_fast,
  output logic               err_slow,
  output logic               yank,
  output logic               sync
);

  logic [2:0]         fcom_s;
  logic [1:0]         sec_s;
  logic [DIV_W-1:0]   div_cnt, div_last;
  logic               once_r, tach_r, ref_r, yank_r;
  logic [SPEED_W-1:0] ref_cnt;

  wire                fcom_edge = fcom_s[1] ^ fcom_s[2];
  wire [SPEED_W-1:0]  ref_len   = ~speed_word_n;
  wire                tach_src  = sector_mode ? sec_s[1] : once_r;
  wire                tach_rise = tach_src & ~tach_r;

  always_comb begin
    case (pole_sel)
      2'b00:   div_last = DIV_W'(23);
      2'b01:   div_last = DIV_W'(11);
      2'b10:   div_last = DIV_W'(47);
      default: div_last = DIV_W'(35);
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fcom_s <= '0;
      sec_s  <= '0;
    end else begin
      fcom_s <= {fcom_s[1:0], fcom};
      sec_s  <= {sec_s[0], sector_in};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_cnt <= '0;
      once_r  <= 1'b0;
    end else if (fcom_edge) begin
      if (div_cnt >= div_last) begin
        div_cnt <= '0;
        once_r  <= ~once_r;
      end else begin
        div_cnt <= div_cnt + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tach_r  <= 1'b0;
      ref_r   <= 1'b0;
      ref_cnt <= '0;
      yank_r  <= 1'b1;
    end else begin
      tach_r <= tach_src;
      if (tach_rise && ref_len != '0) begin
        ref_r   <= 1'b1;
        ref_cnt <= ref_len - 1'b1;
      end else if (tach_rise) begin
        ref_r <= 1'b0;
      end else if (ref_r) begin
        if (ref_cnt == '0) ref_r <= 1'b0;
        else               ref_cnt <= ref_cnt - 1'b1;
      end
      if (err_fast) yank_r <= 1'b0;
    end
  end

  assign tach      = tach_r;
  assign ref_pulse = ref_r;
  assign err_fast  = ref_r & ~tach_r;
  assign err_slow  = tach_r & ~ref_r;
  assign yank      = yank_r;
  assign sync      = tach_r | ref_r;

  AST_REF_NEEDS_TACH: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ref_r) |-> $rose(tach_r)); // R3
  AST_DIV_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    div_cnt <= 6'd47); // R1
  AST_YANK_STAYS_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    !yank_r |=> !yank_r); // R7
  AST_YANK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    err_fast |=> !yank_r); // R7
  AST_SECTOR_FOLLOW: assert property (@(posedge clk) disable iff (!rst_n)
    (sector_mode && $stable(sector_mode)) |=> (tach_r == $past(sec_s[1]))); // R2

endmodule

// File: tb/test_fll_speed_detector.sv
module test_fll_speed_detector;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic fcom = 1'b0, sector_in = 1'b0, sector_mode = 1'b0;
  logic [1:0]  pole_sel = 2'b00;
  logic [13:0] speed_word_n = '1;
  logic tach, ref_pulse, err_fast, err_slow, yank, sync;

  int total = 0;
  int bad = 0;

  always #4 clk = ~clk;

  fll_speed_detector i_fll_speed_detector (
    .clk(clk), .rst_n(rst_n), .fcom(fcom), .sector_in(sector_in),
    .sector_mode(sector_mode), .pole_sel(pole_sel), .speed_word_n(speed_word_n),
    .tach(tach), .ref_pulse(ref_pulse), .err_fast(err_fast), .err_slow(err_slow),
    .yank(yank), .sync(sync)
  );

  // {pole code, fcom toggles per tach toggle}
  localparam logic [3:0][7:0] VEC = '{
    {2'b11, 6'd36}, {2'b10, 6'd48}, {2'b01, 6'd12}, {2'b00, 6'd24}
  };

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    fcom = 1'b0; sector_in = 1'b0;
    tick(2);
    rst_n = 1'b1;
    tick(1);
  endtask

  int nf, ns, nr, y_before;

  task automatic sector_pulse(input int high);
    nf = 0; ns = 0; nr = 0;
    sector_in = 1'b1;
    for (int i = 0; i < high; i++) begin
      tick(1);
      nf += int'(err_fast); ns += int'(err_slow); nr += int'(ref_pulse);
    end
    sector_in = 1'b0;
    for (int i = 0; i < 80; i++) begin
      tick(1);
      nf += int'(err_fast); ns += int'(err_slow); nr += int'(ref_pulse);
    end
  endtask

  initial begin
    #2_000_000;
    total++; bad++;
    $display("FAIL watchdog actual=1 expected=0");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    tick(1);
    // R9 reset state
    check(tach == 0 && ref_pulse == 0 && err_fast == 0 && err_slow == 0 && sync == 0,
          "R9 outputs", int'({tach, ref_pulse, err_fast, err_slow, sync}), 0);
    check(yank == 1, "R9 yank", int'(yank), 1);

    // R1 divider for each pole code
    for (int v = 0; v < 4; v++) begin
      pole_sel = VEC[v][7:6];
      do_reset();
      for (int k = 0; k < int'(VEC[v][5:0]) - 1; k++) begin
        fcom = ~fcom; tick(4);
      end
      check(tach == 0, "R1 before last toggle", int'(tach), 0);
      fcom = ~fcom; tick(4);
      check(tach == 1, "R1 after 3xP toggles", int'(tach), 1);
    end

    // R10 zero reference: err_slow through the whole tach high time
    sector_mode = 1'b1;
    speed_word_n = '1;
    do_reset();
    sector_pulse(12);
    check(nr == 0, "R10 no ref", nr, 0);
    check(ns == 12, "R10 err_slow width", ns, 12);

    // R2 latency, R3 ref length, R8 sync
    speed_word_n = ~14'd20;
    do_reset();
    check(sync == 0, "R8 idle sync", int'(sync), 0);
    sector_in = 1'b1;
    tick(2);
    check(tach == 0, "R2 not yet", int'(tach), 0);
    tick(1);
    check(tach == 1, "R2 third edge", int'(tach), 1);
    check(ref_pulse == 1, "R3 ref starts with tach", int'(ref_pulse), 1);
    check(sync == 1, "R8 sync busy", int'(sync), 1);
    nr = 0;
    while (ref_pulse && nr < 200) begin nr++; tick(1); end
    check(nr == 20, "R3 ref length 20", nr, 20);
    sector_in = 1'b0;
    tick(6);

    // R5 slow motor: tach high 30, ref 20
    do_reset();
    sector_pulse(30);
    check(ns == 10 && nf == 0, "R5 err_slow width", ns, 10);
    check(yank == 1, "R7 yank kept without err_fast", int'(yank), 1);

    // R4/R7 fast motor: tach high 10, ref 20
    do_reset();
    y_before = int'(yank);
    sector_pulse(10);
    check(nf == 10 && ns == 0, "R4 err_fast width", nf, 10);
    check(y_before == 1 && yank == 0, "R7 yank cleared", int'(yank), 0);
    sector_pulse(30);
    check(yank == 0, "R7 yank stays low", int'(yank), 0);

    // R6 equal lengths
    do_reset();
    sector_pulse(20);
    check(nf == 0 && ns == 0, "R6 no error on match", nf + ns, 0);

    // R3 other weights: word for 5, tach 10 => err_slow 5
    speed_word_n = ~14'd5;
    do_reset();
    sector_pulse(10);
    check(nr == 5, "R3 ref length 5", nr, 5);
    check(ns == 5, "R5 err_slow width 5", ns, 5);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule